// File: doc/BRIEF.md
# HDLC Shared-Bus Arbitration and Collision Controller

This block lets one station send frames on a shared, wired-AND HDLC line. Several stations drive the line in open-drain fashion, so any station that drives a 0 pulls the line low. A one on the line is the recessive level. Each station reads back the line level on its CTS input. An upstream framer supplies a bit stream that already carries the flags, the zero-bit stuffing and the CRC. The framer advances one bit for each take strobe, rewinds to the first bit of the frame on a retry strobe, and drops its request on a done strobe.

The block stays idle until the framer raises its request. It then counts line samples that read one, and starts to send only after a run of eight of them. While it sends, it compares each bit it drove with the line level sampled in the middle of that bit. If it drove a 1 and read back a 0, another station holds the line. The block releases the line at once, asks the framer to start the frame again, and goes back to counting idle ones. A station that drives 0 never detects a loss, so exactly one contender completes its frame. When a frame opens with the 0x7E flag against a stuffed frame already on the line, the loss shows up within the first byte. RTS covers the transmission, with an optional one-bit delay. A 4-bit counter reports how many collisions the current frame has suffered.

Top module: `hdlc_bus_arbiter`

## Requirements
- R1: While reset is asserted and afterwards until a frame is requested, txd_o is 1, rts_o is 0, coll_cnt_o is 0, and the take, retry and done strobes are 0.
- R2: The bit clock tclk_i is brought in through a two-flop synchronizer. All bit-time actions (line sampling, loading a bit, the loss decision) happen on the third rising clk edge after the first clk edge that samples tclk_i high. A take strobe is never raised on any other edge.
- R3: With a request pending, the block counts bit-time samples of cts_i that read 1. On the bit-time edge that counts the eighth consecutive 1, it drives the first frame bit on txd_o and raises src_take_o.
- R4: A cts_i sample of 0 while counting resets the run of ones to zero, so sending starts only after eight further consecutive ones.
- R5: While sending, at a bit-time edge where txd_o is 1 and cts_i reads 0, the block raises src_retry_o in the cycle before that edge. On that edge it sets txd_o to 1, clears rts_o, and restarts the idle-ones count from zero.
- R6: While sending, when no loss occurs at a bit-time edge and the current bit is not the last, the block raises src_take_o and drives src_bit_i on txd_o at that edge. Bits reach the line in the order the framer offers them, and at most one of take, retry and done is high in any cycle.
- R7: At the bit-time edge that ends the bit marked by src_last_i without a loss, the block raises src_done_o, returns txd_o to 1, clears rts_o and goes idle.
- R8: With rts_delay_i at 0, rts_o is 1 from the edge that drives the first bit until the edge that ends the last bit, or until a loss. With rts_delay_i at 1, rts_o rises one bit time later.
- R9: txd_o is 1 at all times except while a frame bit of value 0 is being driven.
- R10: coll_cnt_o goes up by one on each loss and stops at 15. It clears to 0 when a new request leaves the idle state, and keeps its value after the frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tclk_i | input | 1 | Transmit bit clock; its rising edge marks mid-bit |
| cts_i | input | 1 | Line level read back from the shared bus |
| rts_delay_i | input | 1 | 1 delays rts_o by one bit time |
| src_valid_i | input | 1 | Framer has a frame to send |
| src_bit_i | input | 1 | Current stuffed frame bit offered by the framer |
| src_last_i | input | 1 | Current bit is the final bit of the closing flag |
| src_take_o | output | 1 | Bit consumed; framer advances on this edge |
| src_retry_o | output | 1 | Arbitration lost; framer rewinds to the first bit |
| src_done_o | output | 1 | Frame completed; framer drops its request |
| txd_o | output | 1 | Open-drain style line drive (1 = released) |
| rts_o | output | 1 | Request-to-send, high while the frame is on the line |
| coll_cnt_o | output | 4 | Collisions of the current frame, saturating at 15 |

## Verification
The hardest case to reach is a loss at a chosen bit of the frame, and then the same loss repeated often enough to drive the counter past saturation. A collision needs a contender whose bits line up exactly with the station's own bit times. The bench therefore models a second station as a queue of levels that is popped at each bit-time edge and ANDed with txd_o to form cts_i. Starting each frame just after a bit edge makes it possible to work out which queue entry lands on which frame bit. A repeated pattern of two zeros followed by eight ones then causes eighteen losses on the second flag bit before the line frees up.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_HUNT = 2'd1,
    ARB_SEND = 2'd2
  } arb_state_e;

endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hb_tick_gen.sv
module hb_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_i,
  output logic tick_o
);

  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], tclk_i};
    end
  end

  // one pulse per bit: synchronized level high, one stage older still low
  assign tick_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

endmodule

// File: rtl/hb_idle_hunter.sv
module hb_idle_hunter #(
  parameter int IDLE_ONES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_en_i,
  input  logic tick_i,
  input  logic cts_i,
  output logic go_o
);

  localparam int CNT_W = $clog2(IDLE_ONES + 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(IDLE_ONES - 1);

  logic [CNT_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    go_o  = 1'b0;
    if (!hunt_en_i) begin
      run_d = '0;
    end else if (tick_i) begin
      if (!cts_i) begin
        run_d = '0;
      end else if (run_q == RUN_LAST) begin
        run_d = '0;
        go_o  = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/hb_coll_counter.sv
module hb_coll_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hdlc_bus_arbiter.sv
module hdlc_bus_arbiter
  import hb_pkg::*;
#(
  parameter int IDLE_ONES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int COLL_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tclk_i,
  input  logic              cts_i,
  input  logic              rts_delay_i,
  input  logic              src_valid_i,
  input  logic              src_bit_i,
  input  logic              src_last_i,
  output logic              src_take_o,
  output logic              src_retry_o,
  output logic              src_done_o,
  output logic              txd_o,
  output logic              rts_o,
  output logic [COLL_W-1:0] coll_cnt_o
);

  logic       rst_int_n;
  logic       tick;
  logic       hunt_go;
  arb_state_e state_q, state_d;
  logic       txd_q, txd_d;
  logic       last_q, last_d;
  logic       rts_q, rts_d;
  logic       take, retry, done, new_frame;

  hb_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  hb_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick_gen (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tclk_i (tclk_i),
    .tick_o (tick)
  );

  hb_idle_hunter #(.IDLE_ONES(IDLE_ONES)) u_idle_hunter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hunt_en_i (state_q == ARB_HUNT),
    .tick_i    (tick),
    .cts_i     (cts_i),
    .go_o      (hunt_go)
  );

  hb_coll_counter #(.CNT_W(COLL_W)) u_coll_counter (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (new_frame),
    .inc_i (retry),
    .cnt_o (coll_cnt_o)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    txd_d     = txd_q;
    last_d    = last_q;
    rts_d     = rts_q;
    take      = 1'b0;
    retry     = 1'b0;
    done      = 1'b0;
    new_frame = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        txd_d = 1'b1;
        rts_d = 1'b0;
        if (src_valid_i) begin
          state_d   = ARB_HUNT;
          new_frame = 1'b1;
        end
      end
      ARB_HUNT: begin
        txd_d = 1'b1;
        rts_d = 1'b0;
        if (hunt_go) begin
          state_d = ARB_SEND;
          txd_d   = src_bit_i;
          last_d  = src_last_i;
          rts_d   = ~rts_delay_i;
          take    = 1'b1;
        end
      end
      ARB_SEND: begin
        if (tick) begin
          if (txd_q && !cts_i) begin
            // released a one, line reads zero: another station owns the bus
            retry   = 1'b1;
            txd_d   = 1'b1;
            rts_d   = 1'b0;
            state_d = ARB_HUNT;
          end else if (last_q) begin
            done    = 1'b1;
            txd_d   = 1'b1;
            rts_d   = 1'b0;
            state_d = ARB_IDLE;
          end else begin
            take    = 1'b1;
            txd_d   = src_bit_i;
            last_d  = src_last_i;
            rts_d   = 1'b1;
          end
        end
      end
      default: begin
        state_d = ARB_IDLE;
        txd_d   = 1'b1;
        rts_d   = 1'b0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ARB_IDLE;
      txd_q   <= 1'b1;
      last_q  <= 1'b0;
      rts_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      txd_q   <= txd_d;
      last_q  <= last_d;
      rts_q   <= rts_d;
    end
  end

  assign src_take_o  = take;
  assign src_retry_o = retry;
  assign src_done_o  = done;
  assign txd_o       = txd_q;
  assign rts_o       = rts_q;

endmodule

// File: rtl/hb_arbiter_chk.sv
module hb_arbiter_chk #(
  parameter int COLL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cts_i,
  input logic              src_take_o,
  input logic              src_retry_o,
  input logic              src_done_o,
  input logic              txd_o,
  input logic              rts_o,
  input logic [COLL_W-1:0] coll_cnt_o
);

  assert_loss_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_retry_o |-> (txd_o && !cts_i));

  assert_release_on_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_retry_o |=> (txd_o && !rts_o));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_take_o, src_retry_o, src_done_o}));

  assert_release_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_done_o |=> (txd_o && !rts_o));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_cnt_o != $past(coll_cnt_o)) |->
      ((coll_cnt_o == '0) || (coll_cnt_o == $past(coll_cnt_o) + 1'b1)));

  assert_count_on_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_cnt_o > $past(coll_cnt_o)) |-> $past(src_retry_o));

endmodule

bind hdlc_bus_arbiter hb_arbiter_chk #(.COLL_W(COLL_W)) u_arbiter_chk (.*);

// File: tb/test_hdlc_bus_arbiter.sv
module test_hdlc_bus_arbiter;

  localparam int HALF_BIT  = 4;
  localparam int BIT_CYC   = 2 * HALF_BIT;
  localparam int RUN_NEED  = 8;
  localparam int COLL_TOP  = 15;
  localparam int FRAME_LEN = 24;

  logic       clk;
  logic       rst_n, tclk, cts, rts_delay, src_valid, src_bit, src_last;
  logic       src_take, src_retry, src_done, txd, rts;
  logic [3:0] coll_cnt;

  bit  frame_q[$];
  bit  oth_q[$];
  logic oth;
  int  idx, req_cnt, ack_cnt;
  int  n_run, n_fail;

  // behavioural reference state
  int  m_state, m_ones, m_coll, age, hunt_run, run_at_start, zero_hits, retries, rts_hi;
  bit  m_txd, m_last, m_rts, t_prev, tick_now;
  bit  d_take, d_retry, d_done;
  bit  bus_bits[$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign cts       = txd & oth;
  assign src_valid = (req_cnt != ack_cnt);
  assign src_bit   = (idx < frame_q.size()) ? frame_q[idx] : 1'b1;
  assign src_last  = (frame_q.size() != 0) && (idx == frame_q.size() - 1);

  hdlc_bus_arbiter i_hdlc_bus_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .tclk_i      (tclk),
    .cts_i       (cts),
    .rts_delay_i (rts_delay),
    .src_valid_i (src_valid),
    .src_bit_i   (src_bit),
    .src_last_i  (src_last),
    .src_take_o  (src_take),
    .src_retry_o (src_retry),
    .src_done_o  (src_done),
    .txd_o       (txd),
    .rts_o       (rts),
    .coll_cnt_o  (coll_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string state_tag(input int s);
    if (s == 2) return "R6 txd while sending";
    if (s == 1) return "R3 txd while counting";
    return "R9 txd idle";
  endfunction

  // framer, second station and reference model, all on the rising edge
  always @(posedge clk) begin
    bit cts_m, e_take, e_retry, e_done, lost;
    if (!rst_n) begin
      m_state = 0; m_ones = 0; m_coll = 0; age = -1; t_prev = 0; tick_now = 0;
      m_txd = 1; m_last = 0; m_rts = 0; hunt_run = 0;
      idx <= 0; ack_cnt <= 0; oth <= 1'b1;
    end else begin
      if (tclk && !t_prev) age = 0;
      else if (age >= 0 && age < 3) age = age + 1;
      t_prev   = tclk;
      tick_now = (age == 2);
      cts_m    = m_txd & oth;
      e_take = 0; e_retry = 0; e_done = 0;
      case (m_state)
        0: if (src_valid) begin m_state = 1; m_ones = 0; m_coll = 0; hunt_run = 0; end
        1: if (tick_now) begin
             if (cts_m) begin
               hunt_run++;
               m_ones++;
               if (m_ones == RUN_NEED) begin
                 run_at_start = hunt_run;
                 m_state = 2; m_ones = 0; m_txd = src_bit; m_last = src_last;
                 m_rts = !rts_delay; e_take = 1; bus_bits.delete();
               end
             end else begin
               m_ones = 0; hunt_run = 0; zero_hits++;
             end
           end
        default: if (tick_now) begin
             lost = m_txd && !cts_m;
             if (lost) begin
               e_retry = 1; m_coll = (m_coll < COLL_TOP) ? m_coll + 1 : COLL_TOP;
               m_txd = 1; m_rts = 0; m_state = 1; hunt_run = 0;
             end else begin
               bus_bits.push_back(cts_m);
               if (m_last) begin
                 e_done = 1; m_txd = 1; m_rts = 0; m_state = 0;
                 check(bus_bits.size() == frame_q.size(), "R6 bits on line", bus_bits.size(), frame_q.size());
                 if (bus_bits.size() == frame_q.size())
                   for (int i = 0; i < bus_bits.size(); i++)
                     check(bus_bits[i] == frame_q[i], "R6 line bit order", bus_bits[i], frame_q[i]);
               end else begin
                 m_txd = src_bit; m_last = src_last; m_rts = 1; e_take = 1;
               end
             end
           end
      endcase
      check(d_take == e_take, "R6 take strobe", d_take, e_take);
      check(d_retry == e_retry, "R5 retry strobe", d_retry, e_retry);
      check(d_done == e_done, "R7 done strobe", d_done, e_done);
      if (d_take) check(tick_now, "R2 action on synchronized edge", age, 2);
      // framer reacts to the design's strobes
      if (src_take)  idx <= idx + 1;
      if (src_retry) begin idx <= 0; retries++; end
      if (src_done)  begin idx <= 0; ack_cnt <= ack_cnt + 1; end
      if (tick_now)  oth <= (oth_q.size() > 0) ? oth_q.pop_front() : 1'b1;
    end
  end

  // output comparison away from the active edge
  always @(negedge clk) begin
    d_take = src_take; d_retry = src_retry; d_done = src_done;
    if (rst_n) begin
      check(txd == m_txd, state_tag(m_state), txd, m_txd);
      check(rts == m_rts, "R8 rts level", rts, m_rts);
      check(int'(coll_cnt) == m_coll, "R10 collision count", coll_cnt, m_coll);
      if (rts) rts_hi++;
    end
  end

  function automatic void build_frame(input logic [7:0] data);
    logic [7:0] flag;
    flag = 8'h7E;
    frame_q.delete();
    for (int i = 0; i < 8; i++) frame_q.push_back(flag[i]);
    for (int i = 0; i < 8; i++) frame_q.push_back(data[i]);
    for (int i = 0; i < 8; i++) frame_q.push_back(flag[i]);
  endfunction

  task automatic align_to_tick();
    do @(posedge clk); while (!tick_now);
    @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] data, input bit dly);
    build_frame(data);
    rts_delay = dly;
    req_cnt++;
  endtask

  task automatic wait_done(input string tag);
    int guard;
    guard = 0;
    while (req_cnt != ack_cnt && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(req_cnt == ack_cnt, tag, ack_cnt, req_cnt);
    repeat (3 * BIT_CYC) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    forever begin
      repeat (HALF_BIT) @(negedge clk);
      if (rst_n) tclk = ~tclk;
    end
  end

  initial begin
    int r0, z0, h0;
    n_run = 0; n_fail = 0; req_cnt = 0; retries = 0; rts_hi = 0; zero_hits = 0;
    rst_n = 1'b0; tclk = 1'b0; rts_delay = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(txd == 1'b1, "R1 txd in reset", txd, 1);
    check(rts == 1'b0, "R1 rts in reset", rts, 0);
    check(coll_cnt == 4'd0, "R1 count in reset", coll_cnt, 0);
    check({src_take, src_retry, src_done} == 3'b000, "R1 strobes in reset", {src_take, src_retry, src_done}, 0);
    rst_n = 1'b1;
    repeat (4 * BIT_CYC) @(negedge clk);
    check(txd == 1'b1 && rts == 1'b0, "R1 idle after reset", {txd, rts}, 2);

    // clean frame on a quiet line
    align_to_tick();
    r0 = retries; h0 = rts_hi;
    launch(8'hA5, 1'b0);
    wait_done("R7 clean frame completes");
    check(retries == r0, "R5 no loss on quiet line", retries - r0, 0);
    check(run_at_start == RUN_NEED, "R3 start after eight ones", run_at_start, RUN_NEED);
    check(rts_hi - h0 == FRAME_LEN * BIT_CYC, "R8 rts span", rts_hi - h0, FRAME_LEN * BIT_CYC);
    check(coll_cnt == 4'd0, "R10 clean frame count", coll_cnt, 0);

    // zero in the middle of the idle run
    align_to_tick();
    z0 = zero_hits;
    oth_q = {1'b1, 1'b1, 1'b1, 1'b0};
    launch(8'h3C, 1'b0);
    wait_done("R7 frame after interrupted run");
    check(zero_hits > z0, "R4 zero seen while counting", zero_hits - z0, 1);
    check(run_at_start == RUN_NEED, "R4 full run after clear", run_at_start, RUN_NEED);

    // contender sends a frame aligned with ours and wins at the first data bit
    align_to_tick();
    r0 = retries;
    oth_q.delete();
    for (int i = 0; i < 7; i++) oth_q.push_back(1'b1);
    for (int i = 0; i < 8; i++) oth_q.push_back(i != 0 && i != 7);
    for (int i = 0; i < 8; i++) oth_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) oth_q.push_back(i != 0 && i != 7);
    launch(8'hA5, 1'b0);
    wait_done("R7 frame after one loss");
    check(retries - r0 == 1, "R5 one loss", retries - r0, 1);
    check(coll_cnt == 4'd1, "R10 one collision counted", coll_cnt, 1);

    // repeated losses drive the counter into saturation
    align_to_tick();
    r0 = retries;
    oth_q.delete();
    for (int i = 0; i < 7; i++) oth_q.push_back(1'b1);
    for (int b = 0; b < 18; b++) begin
      oth_q.push_back(1'b0);
      oth_q.push_back(1'b0);
      for (int i = 0; i < 8; i++) oth_q.push_back(1'b1);
    end
    launch(8'h3C, 1'b0);
    wait_done("R7 frame after many losses");
    check(retries - r0 == 18, "R5 eighteen losses", retries - r0, 18);
    check(coll_cnt == 4'd15, "R10 saturation at 15", coll_cnt, 15);

    // new frame clears the count; delayed RTS
    align_to_tick();
    h0 = rts_hi;
    launch(8'h5A, 1'b1);
    repeat (3) @(negedge clk);
    check(coll_cnt == 4'd0, "R10 cleared on new frame", coll_cnt, 0);
    wait_done("R7 delayed-rts frame completes");
    check(rts_hi - h0 == (FRAME_LEN - 1) * BIT_CYC, "R8 delayed rts span", rts_hi - h0, (FRAME_LEN - 1) * BIT_CYC);
    check(txd == 1'b1, "R9 released after frame", txd, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule